// File: doc/BRIEF.md
# Banked Nibble Data Memory Address Decoder

This block turns an 8-bit in-bank offset plus a few bank-steering controls into one location of a 512-nibble data store, or into a strobe for the memory-mapped I/O region. The store holds two 256-nibble banks, numbered 0 and 1. The low 32 nibbles of bank 0 double as four working-register banks of eight registers each. A third bank, numbered 15, is not stored here at all. Any legal access to it leaves as a one-cycle strobe carrying a 7-bit I/O offset, for the peripheral registers outside the block.

A processor core drives one access per cycle. Three addressing modes are available. Direct mode goes through the bank map. Working-register mode uses the 2-bit register-bank select. Stack mode uses a pre-decremented stack pointer that always lands in bank 0. Each access is a single bit, a nibble, or an 8-bit register pair. A bank-enable flag picks the map used by direct mode. When the flag is clear the map is restricted: the lower half of bank 0 plus the I/O half of bank 15. When the flag is set, the bank-select value chooses the bank. An illegal access raises an error pulse and changes nothing.

Top module: `banked_nibble_mem`

## Requirements
- R1: After a synchronous active-low reset, `rd_data`, `acc_err`, `io_sel` and `io_we` are all zero.
- R2: In direct mode (`acc_mode`=0) with `bank_en`=0, offsets 00h–7Fh reach bank 0 at the same offset, and offsets 80h–FFh go to the I/O region. `bank_sel` has no effect in this case.
- R3: In direct mode with `bank_en`=1, a `bank_sel` of 0 reaches bank 0 and a `bank_sel` of 1 reaches bank 1, at the given offset.
- R4: An I/O access sets `io_sel` for exactly the cycle after it. That cycle also carries `io_off` = offset bits 6:0, `io_we` equal to the write flag, and `io_wdata` equal to the write data. The access does not change the nibble store and returns 0 on `rd_data`. Offsets 80h–FFh of bank 15 (`bank_sel`=15 with `bank_en`=1) are I/O accesses.
- R5: In working-register mode (`acc_mode`=1), the access reaches nibble `reg_bank`*8 + offset[2:0] of bank 0.
- R6: In stack mode (`acc_mode`=2), offset bit 0 is treated as 0 and the result is pre-decremented, by 2 for a pair and by 1 otherwise, modulo 256. The access always reaches bank 0, whatever `bank_en` and `bank_sel` hold. A stack pointer of 00h therefore makes a nibble access reach 0FFh.
- R7: A pair access (`acc_size`=2) uses the low nibble at the even address and the high nibble at the next address. In direct or working-register mode, a pair access at an odd offset raises `acc_err` and writes nothing.
- R8: The following accesses raise `acc_err` in the next cycle, write nothing, make no I/O strobe, and return 0 on a read: a `bank_sel` outside {0, 1, 15} with `bank_en`=1, bank 15 offsets 00h–7Fh, `acc_mode`=3, and `acc_size`=3.
- R9: A bit access (`acc_size`=0) writes `acc_wdata[0]` into bit `acc_bit` of the addressed nibble and leaves the other three bits as they were. A bit read returns that bit in `rd_data[0]`, with every other bit zero.
- R10: A read (`acc_we`=0) updates `rd_data` in the cycle after it. A nibble read returns the nibble in bits 3:0 and zeros above. A write leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | 4 | Bank-select value (upper address bits) |
| bank_en | input | 1 | 0: restricted map, 1: full bank selection |
| reg_bank | input | 2 | Active working-register bank |
| acc_valid | input | 1 | Access present this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_mode | input | 2 | 0 direct, 1 working register, 2 stack, 3 reserved |
| acc_size | input | 2 | 0 bit, 1 nibble, 2 pair, 3 reserved |
| acc_addr | input | 8 | In-bank offset, register index or stack pointer |
| acc_bit | input | 2 | Bit index for bit accesses |
| acc_wdata | input | 8 | Write data (pair: high nibble in bits 7:4) |
| rd_data | output | 8 | Read result, one cycle after the read |
| acc_err | output | 1 | Illegal-access pulse |
| io_sel | output | 1 | I/O region access strobe |
| io_we | output | 1 | The strobed I/O access is a write |
| io_off | output | 7 | Offset within the I/O region |
| io_wdata | output | 8 | Write data of the strobed I/O access |

## Verification
The bench fills both stored banks with offset-dependent patterns through the full map. It then reads them back in two ways: as pairs, and through the restricted map with `bank_sel` deliberately set to 1. A wrong bank bit or a missing restriction shows up as a foreign pattern, and the upper half must turn into I/O strobes. Working-register sweeps over every register bank and index, and stack sweeps over every even pointer, are checked through direct reads. These separate register-bank scaling, pre-decrement amount and stack wrap. Illegal selects, odd pairs and reserved codes are followed by reads of the locations they could have hit, to show that no write leaked through. Bit sweeps set and clear every bit position, to show that the neighbouring bits survive.

// File: rtl/nbm_pkg.sv
// Shared encodings for the banked nibble memory decoder.
package nbm_pkg;
    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_WREG   = 2'd1,
        MODE_STACK  = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SIZE_BIT  = 2'd0,
        SIZE_NIB  = 2'd1,
        SIZE_PAIR = 2'd2,
        SIZE_RSVD = 2'd3
    } size_e;
endpackage

// File: rtl/nbm_addr_map.sv
// Combinational address map: turns mode, size, offset and bank controls
// into a physical nibble index (bank bit on top), an I/O flag or an error.
// Assumes OFF_W >= RB_W + RIDX_W and that the I/O region is the upper half
// of the I/O bank.
module nbm_addr_map
    import nbm_pkg::*;
#(
    parameter int OFF_W   = 8,
    parameter int BANK_W  = 4,
    parameter int RB_W    = 2,
    parameter int RIDX_W  = 3,
    parameter int IO_BANK = 15,
    localparam int PHYS_W = OFF_W + 1
) (
    input  mode_e               mode,
    input  size_e               size,
    input  logic [OFF_W-1:0]    addr,
    input  logic                bank_en,
    input  logic [BANK_W-1:0]   bank_sel,
    input  logic [RB_W-1:0]     reg_bank,
    output logic [PHYS_W-1:0]   phys,
    output logic [OFF_W-2:0]    io_off,
    output logic                is_io,
    output logic                bad
);
    logic [OFF_W-1:0] sp_even;
    logic [OFF_W-1:0] sp_dec;

    // Map the access to storage, the I/O region or an error.
    always_comb begin
        phys    = '0;
        is_io   = 1'b0;
        bad     = 1'b0;
        io_off  = addr[OFF_W-2:0];
        sp_even = {addr[OFF_W-1:1], 1'b0};
        sp_dec  = sp_even - ((size == SIZE_PAIR) ? OFF_W'(2) : OFF_W'(1));
        case (mode)
            MODE_DIRECT: begin
                if (!bank_en) begin
                    if (addr[OFF_W-1]) is_io = 1'b1;
                    else               phys  = {1'b0, addr};
                end else if (bank_sel == BANK_W'(0)) begin
                    phys = {1'b0, addr};
                end else if (bank_sel == BANK_W'(1)) begin
                    phys = {1'b1, addr};
                end else if (bank_sel == BANK_W'(IO_BANK)) begin
                    if (addr[OFF_W-1]) is_io = 1'b1;
                    else               bad   = 1'b1;
                end else begin
                    bad = 1'b1;
                end
            end
            MODE_WREG:  phys = PHYS_W'({reg_bank, addr[RIDX_W-1:0]});
            MODE_STACK: phys = {1'b0, sp_dec};
            default:    bad  = 1'b1;
        endcase
        if (size == SIZE_RSVD) bad = 1'b1;
        if (size == SIZE_PAIR && mode != MODE_STACK && addr[0]) bad = 1'b1;
        if (bad) is_io = 1'b0;
    end
endmodule

// File: rtl/nbm_nibble_ram.sv
// Nibble store split into even and odd columns so a register pair is one
// row. Read is combinational and formatted by access size; writes are
// synchronous. The array carries no reset: software initialises it.
module nbm_nibble_ram
    import nbm_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int PHYS_W = 9,
    localparam int ROWS   = 2 ** (PHYS_W - 1),
    localparam int DATA_W = 2 * NIB_W,
    localparam int BIT_W  = $clog2(NIB_W)
) (
    input  logic               clk,
    input  logic               we_en,
    input  size_e              size,
    input  logic [PHYS_W-1:0]  phys,
    input  logic [BIT_W-1:0]   bit_idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_fmt
);
    logic [NIB_W-1:0] col_even [ROWS];
    logic [NIB_W-1:0] col_odd  [ROWS];
    logic [PHYS_W-2:0] row;
    logic [NIB_W-1:0]  cur;
    logic [NIB_W-1:0]  merged;

    // Select the addressed nibble, build the bit-merged value and the read result.
    always_comb begin
        row    = phys[PHYS_W-1:1];
        cur    = phys[0] ? col_odd[row] : col_even[row];
        merged = cur;
        merged[bit_idx] = wdata[0];
        case (size)
            SIZE_PAIR: rd_fmt = {col_odd[row], col_even[row]};
            SIZE_NIB:  rd_fmt = DATA_W'(cur);
            default:   rd_fmt = DATA_W'(cur[bit_idx]);
        endcase
    end

    // Commit a write of one bit, one nibble or a pair.
    always_ff @(posedge clk) begin
        if (we_en) begin
            case (size)
                SIZE_PAIR: begin
                    col_even[row] <= wdata[NIB_W-1:0];
                    col_odd[row]  <= wdata[DATA_W-1:NIB_W];
                end
                SIZE_NIB: begin
                    if (phys[0]) col_odd[row]  <= wdata[NIB_W-1:0];
                    else         col_even[row] <= wdata[NIB_W-1:0];
                end
                default: begin
                    if (phys[0]) col_odd[row]  <= merged;
                    else         col_even[row] <= merged;
                end
            endcase
        end
    end
endmodule

// File: rtl/nbm_io_strobe.sv
// Registers a one-cycle strobe, offset and data for I/O region accesses.
// Offset and data hold their last value between strobes.
module nbm_io_strobe #(
    parameter int OFF_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              we,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic              io_sel,
    output logic              io_we,
    output logic [OFF_W-1:0]  io_off,
    output logic [DATA_W-1:0] io_wdata
);
    // Pulse the strobe and capture the access fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_sel   <= 1'b0;
            io_we    <= 1'b0;
            io_off   <= '0;
            io_wdata <= '0;
        end else begin
            io_sel <= fire;
            io_we  <= fire && we;
            if (fire) begin
                io_off   <= off;
                io_wdata <= wdata;
            end
        end
    end
endmodule

// File: rtl/banked_nibble_mem.sv
// Top: banked nibble data memory with a working-register remap, a stack path
// that ignores the bank-enable flag, and an I/O strobe for the I/O bank.
// One access per cycle; results, errors and strobes appear one cycle later.
module banked_nibble_mem
    import nbm_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int OFF_W   = 8,
    parameter int BANK_W  = 4,
    parameter int RB_W    = 2,
    parameter int RIDX_W  = 3,
    parameter int IO_BANK = 15,
    localparam int PHYS_W = OFF_W + 1,
    localparam int DATA_W = 2 * NIB_W,
    localparam int BIT_W  = $clog2(NIB_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              bank_en,
    input  logic [RB_W-1:0]   reg_bank,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [1:0]        acc_mode,
    input  logic [1:0]        acc_size,
    input  logic [OFF_W-1:0]  acc_addr,
    input  logic [BIT_W-1:0]  acc_bit,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_err,
    output logic              io_sel,
    output logic              io_we,
    output logic [OFF_W-2:0]  io_off,
    output logic [DATA_W-1:0] io_wdata
);
    mode_e              mode;
    size_e              size;
    logic [PHYS_W-1:0]  phys;
    logic [OFF_W-2:0]   map_io_off;
    logic               map_io;
    logic               map_bad;
    logic               ram_hit;
    logic [DATA_W-1:0]  rd_fmt;

    // Decode the access type and whether it hits the store.
    always_comb begin
        mode    = mode_e'(acc_mode);
        size    = size_e'(acc_size);
        ram_hit = acc_valid && !map_bad && !map_io;
    end

    nbm_addr_map #(
        .OFF_W(OFF_W), .BANK_W(BANK_W), .RB_W(RB_W),
        .RIDX_W(RIDX_W), .IO_BANK(IO_BANK)
    ) u_map (
        .mode(mode), .size(size), .addr(acc_addr), .bank_en(bank_en),
        .bank_sel(bank_sel), .reg_bank(reg_bank), .phys(phys),
        .io_off(map_io_off), .is_io(map_io), .bad(map_bad)
    );

    nbm_nibble_ram #(.NIB_W(NIB_W), .PHYS_W(PHYS_W)) u_ram (
        .clk(clk), .we_en(ram_hit && acc_we), .size(size), .phys(phys),
        .bit_idx(acc_bit), .wdata(acc_wdata), .rd_fmt(rd_fmt)
    );

    nbm_io_strobe #(.OFF_W(OFF_W - 1), .DATA_W(DATA_W)) u_io (
        .clk(clk), .rst_n(rst_n), .fire(acc_valid && map_io && !map_bad),
        .we(acc_we), .off(map_io_off), .wdata(acc_wdata),
        .io_sel(io_sel), .io_we(io_we), .io_off(io_off), .io_wdata(io_wdata)
    );

    // Register the read result and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            acc_err <= 1'b0;
        end else begin
            acc_err <= acc_valid && map_bad;
            if (acc_valid && !acc_we) rd_data <= ram_hit ? rd_fmt : '0;
        end
    end

    // R6: stack accesses never leave bank 0
    p_stack_bank0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && mode == MODE_STACK && size != SIZE_RSVD)
            |-> (!map_io && !map_bad && !phys[PHYS_W-1]));

    // R2: the restricted map sends exactly the upper half to I/O
    p_restricted_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && mode == MODE_DIRECT && !bank_en && size == SIZE_NIB)
            |-> (map_io == acc_addr[OFF_W-1]));

    // R7: odd pair offsets outside the stack path raise an error next cycle
    p_odd_pair_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && size == SIZE_PAIR && mode != MODE_STACK && acc_addr[0])
            |=> acc_err);

    // R8: an erroring access never produces an I/O strobe
    p_err_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> !io_sel);

    // R4: the strobe carries the offset of the access before it
    p_io_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> (io_off == $past(acc_addr[OFF_W-2:0])));
endmodule

// File: tb/banked_nibble_mem_tb.sv
`timescale 1ns/1ps
module banked_nibble_mem_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bank_sel = '0;
    logic       bank_en = 1'b0;
    logic [1:0] reg_bank = '0;
    logic       acc_valid = 1'b0;
    logic       acc_we = 1'b0;
    logic [1:0] acc_mode = '0;
    logic [1:0] acc_size = '0;
    logic [7:0] acc_addr = '0;
    logic [1:0] acc_bit = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] rd_data;
    logic       acc_err;
    logic       io_sel;
    logic       io_we;
    logic [6:0] io_off;
    logic [7:0] io_wdata;

    int vectors = 0;
    int fails = 0;
    logic [3:0] mem [512];
    logic [7:0] exp_rd = '0;

    always #2 clk = ~clk;

    banked_nibble_mem u_dut (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .bank_en(bank_en),
        .reg_bank(reg_bank), .acc_valid(acc_valid), .acc_we(acc_we),
        .acc_mode(acc_mode), .acc_size(acc_size), .acc_addr(acc_addr),
        .acc_bit(acc_bit), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .acc_err(acc_err), .io_sel(io_sel), .io_we(io_we), .io_off(io_off),
        .io_wdata(io_wdata)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected placement, derived from the requirement text.
    function automatic void emap(input int mode, input int size, input int addr,
                                 output int phys, output bit io, output bit bad);
        phys = 0; io = 1'b0; bad = 1'b0;
        case (mode)
            0: begin
                if (!bank_en) begin
                    if (addr >= 128) io = 1'b1; else phys = addr;
                end else if (bank_sel == 0) phys = addr;
                else if (bank_sel == 1) phys = 256 + addr;
                else if (bank_sel == 15) begin
                    if (addr >= 128) io = 1'b1; else bad = 1'b1;
                end else bad = 1'b1;
            end
            1: phys = reg_bank * 8 + (addr % 8);
            2: phys = ((addr & 254) - ((size == 2) ? 2 : 1)) & 255;
            default: bad = 1'b1;
        endcase
        if (size == 3) bad = 1'b1;
        if (size == 2 && mode != 2 && (addr % 2) == 1) bad = 1'b1;
        if (bad) io = 1'b0;
    endfunction

    task automatic apply(input int mode, input int size, input bit we, input int addr,
                         input int bitn, input int wd, input string req);
        int phys; bit io; bit bad;
        emap(mode, size, addr, phys, io, bad);
        @(negedge clk);
        acc_valid = 1'b1; acc_we = we; acc_mode = mode[1:0]; acc_size = size[1:0];
        acc_addr = addr[7:0]; acc_bit = bitn[1:0]; acc_wdata = wd[7:0];
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        chk(req, "acc_err", int'(acc_err), int'(bad));
        chk(req, "io_sel", int'(io_sel), int'(io));
        chk(req, "io_we", int'(io_we), int'(io && we));
        if (io) begin
            chk(req, "io_off", int'(io_off), addr & 127);
            if (we) chk(req, "io_wdata", int'(io_wdata), wd & 255);
        end
        if (!we) begin
            if (bad || io) exp_rd = 8'h00;
            else if (size == 2) exp_rd = {mem[phys | 1], mem[phys & 510]};
            else if (size == 1) exp_rd = {4'h0, mem[phys]};
            else exp_rd = {7'h00, mem[phys][bitn]};
        end else if (!bad && !io) begin
            if (size == 2) begin
                mem[phys] = wd[3:0];
                mem[phys + 1] = wd[7:4];
            end else if (size == 1) mem[phys] = wd[3:0];
            else mem[phys][bitn] = wd[0];
        end
        chk(req, "rd_data", int'(rd_data), int'(exp_rd));
    endtask

    task automatic full(input int sel);
        @(negedge clk);
        bank_en = 1'b1; bank_sel = sel[3:0];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "rd_data", int'(rd_data), 0);
        chk("R1", "acc_err", int'(acc_err), 0);
        chk("R1", "io_sel", int'(io_sel), 0);
        chk("R1", "io_we", int'(io_we), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: fill both stored banks through the full map
        full(0);
        for (int a = 0; a < 256; a++) apply(0, 1, 1, a, 0, (a * 7 + 3) & 15, "R3");
        full(1);
        for (int a = 0; a < 256; a++) apply(0, 1, 1, a, 0, (a * 5 + 1) & 15, "R3");
        // R7 / R10: pair reads in both banks
        for (int b = 0; b < 2; b++) begin
            full(b);
            for (int a = 0; a < 256; a += 2) apply(0, 2, 0, a, 0, 0, "R7");
        end
        // R2 / R4: restricted map with bank_sel left at 1
        @(negedge clk); bank_en = 1'b0; bank_sel = 4'd1;
        for (int a = 0; a < 256; a++) apply(0, 1, 0, a, 0, 0, "R2");
        for (int a = 128; a < 256; a += 9) apply(0, 1, 1, a, 0, a ^ 8'hC3, "R4");
        // R4: I/O bank upper half, then stored banks unchanged
        full(15);
        for (int a = 128; a < 256; a += 3) apply(0, 2 * (a % 2 == 0 ? 1 : 0) + (a % 2), 1, a, 0, a ^ 8'h3C, "R4");
        // R8: I/O bank lower half and illegal selects leak nothing
        for (int a = 0; a < 128; a += 5) apply(0, 1, 1, a, 0, 9, "R8");
        for (int s = 2; s < 15; s++) begin
            full(s);
            apply(0, 1, 1, s * 11, 0, 6, "R8");
            apply(0, 1, 0, s * 11, 0, 0, "R8");
        end
        for (int s = 0; s < 2; s++) begin
            full(s);
            for (int a = 0; a < 256; a += 5) apply(0, 1, 0, a, 0, 0, "R8");
        end
        full(0);
        apply(3, 1, 1, 4, 0, 5, "R8");
        apply(0, 3, 1, 4, 0, 5, "R8");
        apply(0, 1, 0, 4, 0, 0, "R8");
        // R7: odd pair writes rejected, neighbours intact
        for (int a = 1; a < 256; a += 22) begin
            apply(0, 2, 1, a, 0, 8'hEE, "R7");
            apply(0, 1, 0, a, 0, 0, "R7");
            apply(0, 1, 0, (a + 1) & 255, 0, 0, "R7");
            apply(0, 1, 0, a - 1, 0, 0, "R7");
        end
        // R5: working registers of every bank, checked through direct reads
        for (int rb = 0; rb < 4; rb++) begin
            @(negedge clk); reg_bank = rb[1:0]; bank_en = 1'b0;
            for (int i = 0; i < 8; i++) apply(1, 1, 1, i + 8 * (i % 2), 0, (rb * 3 + i) & 15, "R5");
            for (int i = 0; i < 8; i += 2) apply(1, 2, 0, i, 0, 0, "R5");
            apply(1, 2, 1, 5, 0, 8'h77, "R5");
        end
        full(0);
        for (int a = 0; a < 32; a++) apply(0, 1, 0, a, 0, 0, "R5");
        // R6: stack pair writes with restrictive controls, read directly
        for (int sp = 0; sp < 256; sp += 2) begin
            @(negedge clk); bank_en = 1'b0; bank_sel = 4'd1;
            apply(2, 2, 1, sp, 0, (sp ^ 8'h5A) & 255, "R6");
            full(0);
            apply(0, 2, 0, (sp - 2) & 255, 0, 0, "R6");
        end
        full(1);
        apply(2, 1, 1, 1, 0, 4'hB, "R6");
        apply(2, 1, 0, 0, 0, 0, "R6");
        apply(2, 0, 0, 0, 3, 0, "R6");
        full(0);
        apply(0, 1, 0, 255, 0, 0, "R6");
        full(1);
        apply(0, 1, 0, 255, 0, 0, "R6");
        // R9: set and clear each bit, neighbours kept
        for (int b = 0; b < 2; b++) begin
            full(b);
            for (int a = 0; a < 256; a += 13) begin
                for (int k = 0; k < 4; k++) begin
                    apply(0, 0, 1, a, k, (a + k) % 2, "R9");
                    apply(0, 0, 0, a, k, 0, "R9");
                end
                apply(0, 1, 0, a, 0, 0, "R9");
            end
        end
        // R10: writes hold the last read value
        full(0);
        apply(0, 1, 0, 77, 0, 0, "R10");
        apply(0, 1, 1, 78, 0, 2, "R10");
        apply(0, 2, 1, 80, 0, 8'h91, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule